// File: doc/BRIEF.md
# Bidirectional Parallel Port with Direction and Override Control

This block is a small parallel I/O port of configurable width (eight bits by default) for a microcontroller-style register bus. Two registers sit behind a one-bit address: an output value register and a direction register. Software writes both through a single write strobe and reads either one back through a combinational read path. Each bit of the direction register decides whether that pin's output driver is enabled. Incoming pin levels cross into the bus clock domain through a flip-flop synchronizer before software can read them.

Each bit can also be taken over from outside. A peripheral may claim a pin and supply its own drive enable and output level, but the direction bit still selects what a read of the value register returns for that bit. An analog function may claim a pin outright. It then disables all digital drive on that pin, forces the read value of that bit to zero, and takes priority over any peripheral claim on the same bit.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset, the value register and the direction register are both zero, so `pin_oe` and `pin_out` are all zero.
- R2: A write with `reg_we`=1 and `reg_addr`=0 stores `reg_wdata` in the value register on that clock edge, whatever the direction bits are. With no override, `pin_out` shows the stored value from the next cycle on, even for bits whose driver is off.
- R3: A write with `reg_we`=1 and `reg_addr`=1 stores `reg_wdata` in the direction register. With no override, `pin_oe` matches it from the clock edge of the write onward and keeps its old value before that edge (1 = drive, 0 = input).
- R4: While `reg_addr`=0, a bit whose direction is 0 and whose analog claim is off reads the level `pin_in` had two rising clock edges earlier. The level is not yet visible after only one edge.
- R5: While `reg_addr`=0, a bit whose direction is 1 and whose analog claim is off reads the stored value register bit.
- R6: A bit with `per_en`=1 and `ana_en`=0 drives `pin_oe` from `per_oe` and `pin_out` from `per_out`. Its read source is still chosen by its direction bit as in R4 and R5.
- R7: A bit with `ana_en`=1 has `pin_oe`=0 and `pin_out`=0 and reads 0 while `reg_addr`=0. This holds even when `per_en` is also set for that bit.
- R8: While `reg_addr`=1, `reg_rdata` returns the direction register unchanged, whatever the override inputs are.
- R9: If a value is written while a pin is an input and the pin is then switched to output, `pin_out` already carries that value in the first cycle in which `pin_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 value, 1 direction |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Combinational read data |
| pin_in | input | WIDTH | Asynchronous pin levels from the pads |
| per_en | input | WIDTH | Per-bit peripheral takeover |
| per_oe | input | WIDTH | Peripheral drive enable |
| per_out | input | WIDTH | Peripheral output level |
| ana_en | input | WIDTH | Per-bit analog takeover |
| pin_oe | output | WIDTH | Per-pin output driver enable |
| pin_out | output | WIDTH | Per-pin output level |

## Verification
The properties treat `pin_in` as a level that may change at any time. The latency check only asks that the read value match the level sampled two edges earlier, counted from the third cycle after reset. The write-effect properties hold only when no override bit is set in the cycle after the write. For this reason the bench leaves `per_en` and `ana_en` at zero during its register-write scenarios and sets them only after the registers are settled. The bench changes every input on the falling clock edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic {
    SEL_VALUE = 1'b0,
    SEL_DIR   = 1'b1
  } gpio_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] value_q,
  output logic [WIDTH-1:0] dir_q
);
  import gpio_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '0;
      dir_q   <= '0;
    end else if (we) begin
      if (gpio_sel_e'(addr) == SEL_VALUE) value_q <= wdata;
      else                                dir_q   <= wdata;
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[LAST];
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] value_q,
  input  logic [WIDTH-1:0] per_en,
  input  logic [WIDTH-1:0] per_oe,
  input  logic [WIDTH-1:0] per_out,
  input  logic [WIDTH-1:0] ana_en,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      if (ana_en[b]) begin
        pin_oe[b]  = 1'b0;
        pin_out[b] = 1'b0;
      end else if (per_en[b]) begin
        pin_oe[b]  = per_oe[b];
        pin_out[b] = per_out[b];
      end else begin
        pin_oe[b]  = dir_q[b];
        pin_out[b] = value_q[b];
      end
    end
  end
endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux #(
  parameter int WIDTH = 8
) (
  input  logic             addr,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] value_q,
  input  logic [WIDTH-1:0] sync_in,
  input  logic [WIDTH-1:0] ana_en,
  output logic [WIDTH-1:0] rdata
);
  import gpio_pkg::*;

  logic [WIDTH-1:0] port_view;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      if (ana_en[b])     port_view[b] = 1'b0;
      else if (dir_q[b]) port_view[b] = value_q[b];
      else               port_view[b] = sync_in[b];
    end
  end

  assign rdata = (gpio_sel_e'(addr) == SEL_DIR) ? dir_q : port_view;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] per_en,
  input  logic [WIDTH-1:0] per_oe,
  input  logic [WIDTH-1:0] per_out,
  input  logic [WIDTH-1:0] ana_en,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out
);
  logic [WIDTH-1:0] value_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pin_sync;

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .value_q(value_q), .dir_q(dir_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio_pinmux #(.WIDTH(WIDTH)) u_pinmux (
    .dir_q(dir_q), .value_q(value_q), .per_en(per_en), .per_oe(per_oe),
    .per_out(per_out), .ana_en(ana_en), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  gpio_readmux #(.WIDTH(WIDTH)) u_readmux (
    .addr(reg_addr), .dir_q(dir_q), .value_q(value_q), .sync_in(pin_sync),
    .ana_en(ana_en), .rdata(reg_rdata)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic             reg_addr,
  input logic [WIDTH-1:0] reg_wdata,
  input logic [WIDTH-1:0] reg_rdata,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] per_en,
  input logic [WIDTH-1:0] per_oe,
  input logic [WIDTH-1:0] per_out,
  input logic [WIDTH-1:0] ana_en,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] dir_q
);
  logic [1:0] run_cyc;

  always_ff @(posedge clk) begin
    if (rst)                run_cyc <= '0;
    else if (run_cyc != 2'd3) run_cyc <= run_cyc + 2'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 || per_en != '0) && (pin_out == '0 || per_en != '0));

  assert_value_write_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !reg_addr) |=>
      (per_en != '0 || ana_en != '0 || pin_out == $past(reg_wdata)));

  assert_dir_write_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr) |=>
      (per_en != '0 || ana_en != '0 || pin_oe == $past(reg_wdata)));

  assert_periph_drive_R6: assert property (@(posedge clk) disable iff (rst)
    ((per_en & ~ana_en & ((pin_oe ^ per_oe) | (pin_out ^ per_out))) == '0));

  assert_analog_off_R7: assert property (@(posedge clk) disable iff (rst)
    ((ana_en & (pin_oe | pin_out)) == '0));

  assert_analog_read_R7: assert property (@(posedge clk) disable iff (rst)
    !reg_addr |-> ((reg_rdata & ana_en) == '0));

  assert_dir_read_R8: assert property (@(posedge clk) disable iff (rst)
    reg_addr |-> (reg_rdata == dir_q));

  if (SYNC_STAGES == 2) begin : g_lat
    assert_sync_latency_R4: assert property (@(posedge clk) disable iff (rst)
      (!reg_addr && run_cyc >= 2'd2) |->
        (((reg_rdata ^ $past(pin_in, 2)) & ~dir_q & ~ana_en) == '0));
  end

  logic unused_ok;
  assign unused_ok = ^{reg_wdata, pin_in};
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
  .per_en(per_en), .per_oe(per_oe), .per_out(per_out), .ana_en(ana_en),
  .pin_oe(pin_oe), .pin_out(pin_out), .dir_q(dir_q)
);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_we = 1'b0;
  logic         reg_addr = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] per_en = '0;
  logic [W-1:0] per_oe = '0;
  logic [W-1:0] per_out = '0;
  logic [W-1:0] ana_en = '0;
  logic [W-1:0] pin_oe;
  logic [W-1:0] pin_out;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  gpio_port #(.WIDTH(W), .SYNC_STAGES(2)) i_gpio_port (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .per_en(per_en), .per_oe(per_oe), .per_out(per_out), .ana_en(ana_en),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [W-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [W-1:0] r;
    @(negedge clk);
    check("R1 oe", pin_oe, '0);
    check("R1 out", pin_out, '0);
    rd(1'b1, r); check("R1 dir", r, '0);
    rd(1'b0, r); check("R1 value", r, '0);
  endtask

  task automatic t_input_sync;
    logic [W-1:0] r;
    rd(1'b0, r);
    pin_in = 8'hA5;
    @(negedge clk); rd(1'b0, r); check("R4 one edge", r, 8'h00);
    @(negedge clk); rd(1'b0, r); check("R4 two edges", r, 8'hA5);
    pin_in = 8'h5A;
    @(negedge clk); rd(1'b0, r); check("R4 one edge b", r, 8'hA5);
    @(negedge clk); rd(1'b0, r); check("R4 two edges b", r, 8'h5A);
  endtask

  task automatic t_oe_timing;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 8'hF0;
    #1 check("R3 before edge", pin_oe, 8'h00);
    @(negedge clk);
    reg_we = 1'b0;
    check("R3 after edge", pin_oe, 8'hF0);
  endtask

  task automatic t_mixed_read;
    logic [W-1:0] r;
    wr(1'b0, 8'h3C);
    pin_in = 8'hFF;
    repeat (2) @(negedge clk);
    check("R2 pin_out", pin_out, 8'h3C);
    rd(1'b0, r); check("R5 mixed read", r, 8'h3F);
    rd(1'b1, r); check("R8 dir read", r, 8'hF0);
  endtask

  task automatic t_preload;
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h81);
    check("R2 latched while input", pin_out, 8'h81);
    check("R2 drivers off", pin_oe, 8'h00);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 8'hFF;
    @(negedge clk);
    reg_we = 1'b0;
    check("R9 oe on", pin_oe, 8'hFF);
    check("R9 out preloaded", pin_out, 8'h81);
  endtask

  task automatic t_periph;
    logic [W-1:0] r;
    wr(1'b1, 8'h0F);
    wr(1'b0, 8'h55);
    pin_in = 8'h90;
    repeat (2) @(negedge clk);
    per_en = 8'hF0; per_oe = 8'hA0; per_out = 8'hC0;
    #1;
    check("R6 oe", pin_oe, 8'hAF);
    check("R6 out", pin_out, 8'hC5);
    rd(1'b0, r); check("R6 read by dir", r, 8'h95);
  endtask

  task automatic t_analog;
    logic [W-1:0] r;
    per_en = '0;
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'hFF);
    pin_in = 8'hFF;
    per_en = 8'hF0; per_oe = 8'hF0; per_out = 8'hF0;
    ana_en = 8'h11;
    repeat (2) @(negedge clk);
    check("R7 oe", pin_oe, 8'hEE);
    check("R7 out", pin_out, 8'hEE);
    rd(1'b0, r); check("R7 read zero", r, 8'hEE);
    rd(1'b1, r); check("R8 dir with analog", r, 8'hFF);
    ana_en = '0;
    #1;
    rd(1'b0, r); check("R7 released", r, 8'hFF);
    per_en = '0;
  endtask

  initial begin : watchdog
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_input_sync();
    t_oe_timing();
    t_mixed_read();
    t_preload();
    t_periph();
    t_analog();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule